// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block holds the byte buffering of a 16550-style serial port. A host reaches it through a small register port. It writes bytes for transmission at offset 0, reads received bytes at offset 0, writes the FIFO control byte at offset 2 and reads the line status byte at offset 5. The serial side delivers received bytes and break events as one-cycle strobes. It takes transmit bytes through a valid/ready handshake.

With buffering switched on, each direction uses a 16-entry FIFO. The two sides handle a full buffer in opposite ways. A byte that arrives into a full receive FIFO is lost. A host byte written into a full transmit FIFO pushes out the oldest byte. With buffering switched off, each direction holds a single byte. The block reports the receive occupancy, the selected receive trigger threshold and the DMA-mode selection to the neighbouring interrupt and timing logic.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the status byte at offset 5 reads 0x60, rx_count is 0, trig_level is 1, dma_mode is 0, tx_valid is 0 and buffering is off.
- R2: A control write keeps only bits 7, 6, 3 and 0. Bit 0 switches buffering on, bit 3 drives dma_mode, and bits 7:6 select a trig_level of 1, 4, 8 or 14 bytes for codes 0 to 3. Bits 1 and 2 are one-shot flush requests that are not kept.
- R3: With buffering on, received bytes are read back at offset 0 in arrival order, and rx_count follows the number of stored bytes.
- R4: With buffering on, a byte that arrives while the receive FIFO holds 16 bytes is discarded. The stored bytes stay intact, and status bit 1 (overrun) is set.
- R5: With buffering on, a host write while the transmit FIFO holds 16 bytes drops the oldest byte and appends the new one, so the last 16 written bytes are sent.
- R6: With buffering off, a byte that arrives while status bit 0 (data ready) is set replaces the held byte and sets overrun.
- R7: A data read from an empty receive FIFO returns 0x00. A data read that leaves the receive side empty clears data ready and status bit 4 (break).
- R8: A break event stores a 0x00 byte and sets both break and data ready.
- R9: A status read clears break and overrun, unless a new event sets them in the same cycle.
- R10: A control write equal to the stored control byte changes nothing, including FIFO contents.
- R11: A control write that differs from the stored byte flushes the receive side when bit 1 is set, and flushes the transmit side when bit 2 is set. A change of bit 0 flushes both. A receive flush clears data ready and break, and wins over a byte arriving in the same cycle.
- R12: tx_valid is high while a byte waits and drops when the last one is taken with tx_ready. With buffering off, a new host write replaces the waiting byte. Status bits 5 and 6 are both 1 exactly when no transmit byte waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed offset, valid in the cycle of the read |
| rx_valid | input | 1 | Received byte strobe |
| rx_break | input | 1 | Received break strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | A transmit byte is waiting |
| tx_data | output | 8 | Waiting transmit byte |
| tx_ready | input | 1 | Serializer takes the waiting byte |
| rx_count | output | 5 | Receive FIFO occupancy |
| trig_level | output | 5 | Receive trigger threshold in bytes |
| dma_mode | output | 1 | Stored DMA mode selection |

## Verification
Read data is combinational from the current state, so the bench samples reg_rdata inside the read cycle, just after driving the strobe and before the edge that applies the read's side effects. Every state change, including counts, status bits, flushes and tx_valid, appears at the first clock edge after the strobe. The bench samples these one time unit after that edge, with no extra latency. Sweeps over fill levels from 0 to 18 bytes (receive) and 0 to 20 bytes (transmit) compare against expected values worked out as min/max arithmetic on the byte index.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd5;

  localparam logic [7:0] CTRL_KEEP = 8'hC9;

  localparam int ST_DR   = 0;
  localparam int ST_OE   = 1;
  localparam int ST_BI   = 4;
  localparam int ST_HOLD = 5;
  localparam int ST_IDLE = 6;

  function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // A change of the enable bit turns into both flush requests.
  function automatic logic [7:0] ctrl_effective(input logic [7:0] wr, input logic [7:0] cur);
    return wr | (((wr ^ cur) & 8'h01) != 8'h00 ? 8'h06 : 8'h00);
  endfunction

  function automatic logic [7:0] line_status(input logic dr, input logic oe,
                                             input logic bi, input logic idle);
    logic [7:0] s;
    s          = '0;
    s[ST_DR]   = dr;
    s[ST_OE]   = oe;
    s[ST_BI]   = bi;
    s[ST_HOLD] = idle;
    s[ST_IDLE] = idle;
    return s;
  endfunction

endpackage

// File: rtl/uart_fifo_ctrl_reg.sv
module uart_fifo_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic       fifo_en,
  output logic       dma_mode,
  output logic [1:0] trig_sel,
  output logic       rx_flush,
  output logic       tx_flush
);

  logic [7:0] ctrl_q;
  logic       changed;
  logic [7:0] eff;

  assign changed  = wr_stb && (wdata != ctrl_q);
  assign eff      = ctrl_effective(wdata, ctrl_q);
  assign rx_flush = changed && eff[1];
  assign tx_flush = changed && eff[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (changed) ctrl_q <= wdata & CTRL_KEEP;
  end

  assign fifo_en  = ctrl_q[0];
  assign dma_mode = ctrl_q[3];
  assign trig_sel = ctrl_q[7:6];

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int W           = 8,
  parameter int DEPTH       = 16,
  parameter int DROP_OLDEST = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       push_lost
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop, evict;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  generate
    if (DROP_OLDEST != 0) begin : g_evict
      assign evict = push && full;
    end else begin : g_keep
      assign evict = 1'b0;
    end
  endgenerate

  assign do_pop    = !empty && (pop || evict);
  assign do_push   = push && (!full || do_pop);
  assign push_lost = push && !do_push;
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [2:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  input  logic                       rx_valid,
  input  logic                       rx_break,
  input  logic [7:0]                 rx_data,
  output logic                       tx_valid,
  output logic [7:0]                 tx_data,
  input  logic                       tx_ready,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic [4:0]                 trig_level,
  output logic                       dma_mode
);

  localparam int CW = $clog2(DEPTH + 1);

  // Decoded host accesses
  logic wr_data, wr_ctrl, rd_data, rd_stat;
  assign wr_data = reg_wr && (reg_addr == OFS_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign rd_data = reg_rd && (reg_addr == OFS_DATA);
  assign rd_stat = reg_rd && (reg_addr == OFS_STAT);

  // Control register
  logic       fifo_en, rx_flush, tx_flush;
  logic [1:0] trig_sel;

  uart_fifo_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_ctrl),
    .wdata    (reg_wdata),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .trig_sel (trig_sel),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  assign trig_level = trig_bytes(trig_sel);

  // Receive side
  logic          rx_event, rx_push, rx_pop, rx_full, rx_empty, rx_lost;
  logic [7:0]    rx_byte, rx_dout;

  assign rx_event = rx_valid || rx_break;
  assign rx_byte  = rx_break ? 8'h00 : rx_data;
  assign rx_push  = fifo_en && rx_event;
  assign rx_pop   = fifo_en && rd_data;

  uart_byte_fifo #(.W(8), .DEPTH(DEPTH), .DROP_OLDEST(0)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_push),
    .din       (rx_byte),
    .pop       (rx_pop),
    .dout      (rx_dout),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_lost (rx_lost)
  );

  // Transmit side
  logic          tx_push, tx_pop, tx_full, tx_empty, tx_lost;
  logic [7:0]    tx_dout;
  logic [CW-1:0] tx_count;

  assign tx_push = fifo_en && wr_data;
  assign tx_pop  = fifo_en && tx_ready && !tx_empty;

  uart_byte_fifo #(.W(8), .DEPTH(DEPTH), .DROP_OLDEST(1)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (tx_push),
    .din       (reg_wdata),
    .pop       (tx_pop),
    .dout      (tx_dout),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_lost (tx_lost)
  );

  // Single-byte holding registers used with buffering off
  logic [7:0] rx_hold, thr_q;
  logic       thr_full;

  // Line status state and the events that move it
  logic dr_q, oe_q, bi_q;
  logic rx_take, rx_ovr, rx_clear, tx_idle;

  assign rx_take  = rx_event && !rx_flush;
  assign rx_ovr   = fifo_en ? (rx_lost && !rx_flush) : (rx_take && dr_q);
  assign rx_clear = rd_data && (!fifo_en || rx_count <= CW'(1));
  assign tx_idle  = fifo_en ? tx_empty : !thr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0;
      oe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      if (rx_flush)      dr_q <= 1'b0;
      else if (rx_take)  dr_q <= 1'b1;
      else if (rx_clear) dr_q <= 1'b0;

      if (rx_flush)                     bi_q <= 1'b0;
      else if (rx_take && rx_break)     bi_q <= 1'b1;
      else if (rd_stat || rx_clear)     bi_q <= 1'b0;

      if (rx_ovr)       oe_q <= 1'b1;
      else if (rd_stat) oe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold  <= '0;
      thr_q    <= '0;
      thr_full <= 1'b0;
    end else begin
      if (rx_flush)                rx_hold <= '0;
      else if (!fifo_en && rx_take) rx_hold <= rx_byte;

      if (tx_flush) begin
        thr_full <= 1'b0;
      end else if (!fifo_en && wr_data) begin
        thr_q    <= reg_wdata;
        thr_full <= 1'b1;
      end else if (!fifo_en && tx_ready) begin
        thr_full <= 1'b0;
      end
    end
  end

  assign tx_valid = fifo_en ? !tx_empty : thr_full;
  assign tx_data  = fifo_en ? tx_dout : thr_q;

  always_comb begin
    case (reg_addr)
      OFS_DATA: reg_rdata = fifo_en ? (rx_empty ? 8'h00 : rx_dout) : rx_hold;
      OFS_STAT: reg_rdata = line_status(dr_q, oe_q, bi_q, tx_idle);
      default:  reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_en,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic                       rx_event,
  input logic                       rx_break,
  input logic                       rx_pop,
  input logic                       tx_pop,
  input logic                       wr_data,
  input logic                       rd_stat,
  input logic                       rx_flush,
  input logic                       tx_flush,
  input logic                       rx_ovr,
  input logic                       dr_q,
  input logic                       oe_q,
  input logic                       bi_q,
  input logic [4:0]                 trig_level
);

  localparam int CW = $clog2(DEPTH + 1);

  p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  p_rx_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rx_count == CW'(DEPTH) && rx_event && !rx_pop && !rx_flush
    |=> rx_count == CW'(DEPTH) && oe_q);

  p_tx_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && tx_count == CW'(DEPTH) && wr_data && !tx_pop && !tx_flush
    |=> tx_count == CW'(DEPTH));

  p_single_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && rx_event && dr_q && !rx_flush |=> oe_q && dr_q);

  p_break_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break && !rx_flush |=> bi_q && dr_q);

  p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !rx_ovr && !rx_break |=> !oe_q && !bi_q);

  p_rx_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == '0 && !dr_q);

  p_tx_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_count == '0);

  p_trig_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_level == 5'd1 || trig_level == 5'd4 || trig_level == 5'd8 || trig_level == 5'd14);

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .rx_count   (rx_count),
  .tx_count   (tx_count),
  .rx_event   (rx_event),
  .rx_break   (rx_break),
  .rx_pop     (rx_pop),
  .tx_pop     (tx_pop),
  .wr_data    (wr_data),
  .rd_stat    (rd_stat),
  .rx_flush   (rx_flush),
  .tx_flush   (tx_flush),
  .rx_ovr     (rx_ovr),
  .dr_q       (dr_q),
  .oe_q       (oe_q),
  .bi_q       (bi_q),
  .trig_level (trig_level)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic [4:0] rx_count;
  logic [4:0] trig_level;
  logic       dma_mode;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  uart_fifo_ctl #(.DEPTH(DEPTH)) i_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_count(rx_count), .trig_level(trig_level), .dma_mode(dma_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic rx_brk();
    @(negedge clk);
    rx_break = 1'b1;
    @(posedge clk); #1;
    rx_break = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk);
    tx_ready = 1'b1;
    @(posedge clk); #1;
    tx_ready = 1'b0;
  endtask

  function automatic logic [7:0] rx_pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 11 + 200) & 255);
  endfunction

  function automatic int trig_of(input int sel);
    return (sel == 0) ? 1 : (sel == 3) ? 14 : 4 * sel;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 rx_count", rx_count, 0);
    check("R1 trig_level", trig_level, 1);
    check("R1 dma_mode", dma_mode, 0);
    check("R1 tx_valid", tx_valid, 0);
    reg_read(3'd5, d); check("R1 status", d, 8'h60);

    // R2 trigger code and DMA bit sweep
    for (int sel = 0; sel < 4; sel++) begin
      reg_write(3'd2, 8'((sel << 6) | ((sel & 1) << 3) | 1));
      check("R2 trig_level", trig_level, trig_of(sel));
      check("R2 dma_mode", dma_mode, sel & 1);
    end
    reg_write(3'd2, 8'hFF);
    check("R2 keep mask trig", trig_level, 14);
    check("R2 keep mask dma", dma_mode, 1);
    reg_write(3'd2, 8'h01);
    check("R2 trig back to 1", trig_level, 1);

    // R3/R4/R7/R9 receive fill sweep
    for (int k = 0; k <= 18; k++) begin
      int kept;
      kept = (k < DEPTH) ? k : DEPTH;
      reg_write(3'd2, 8'h03);
      reg_read(3'd5, d);
      for (int i = 0; i < k; i++) rx_send(rx_pat(i));
      check("R3 rx_count", rx_count, kept);
      reg_read(3'd5, d);
      check("R4 status after fill", d, 8'h60 | (k > 0 ? 1 : 0) | (k > DEPTH ? 2 : 0));
      reg_read(3'd5, d);
      check("R9 overrun cleared", d, 8'h60 | (k > 0 ? 1 : 0));
      for (int i = 0; i < kept; i++) begin
        reg_read(3'd0, d);
        check("R3 order", d, rx_pat(i));
      end
      reg_read(3'd0, d);
      check("R7 empty read", d, 0);
      reg_read(3'd5, d);
      check("R7 data ready cleared", d, 8'h60);
    end

    // R8 break in FIFO mode
    rx_brk();
    check("R8 break count", rx_count, 1);
    reg_read(3'd0, d); check("R8 break byte", d, 0);
    reg_read(3'd5, d); check("R7 break cleared by drain", d, 8'h60);
    rx_brk();
    rx_send(8'h9C);
    reg_read(3'd5, d); check("R8 break flags", d, 8'h71);
    reg_read(3'd5, d); check("R9 break cleared", d, 8'h61);
    reg_read(3'd0, d); check("R8 null first", d, 0);
    reg_read(3'd5, d); check("R7 not empty keeps ready", d, 8'h61);
    reg_read(3'd0, d); check("R3 byte after break", d, 8'h9C);

    // R10 equal write / R11 flush
    for (int i = 0; i < 3; i++) rx_send(rx_pat(i));
    reg_write(3'd2, 8'h01);
    check("R10 equal write count", rx_count, 3);
    reg_write(3'd2, 8'h41);
    check("R10 no-flush change count", rx_count, 3);
    check("R2 trig 4", trig_level, 4);
    reg_write(3'd2, 8'h43);
    check("R11 rx flush", rx_count, 0);
    reg_read(3'd5, d); check("R11 flush clears ready", d, 8'h60);

    // R11 flush wins over same-cycle receive
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h03;
    rx_valid = 1'b1; rx_data = 8'h5A;
    @(posedge clk); #1;
    reg_wr = 1'b0; rx_valid = 1'b0;
    check("R11 flush priority", rx_count, 0);
    reg_read(3'd5, d); check("R11 flush priority status", d, 8'h60);

    // R5/R12 transmit sweep
    for (int n = 0; n <= 20; n++) begin
      int kept, first;
      kept  = (n < DEPTH) ? n : DEPTH;
      first = n - kept;
      reg_write(3'd2, 8'h05);
      for (int i = 0; i < n; i++) reg_write(3'd0, tx_pat(i));
      reg_read(3'd5, d);
      check("R12 idle bits", d, n > 0 ? 8'h00 : 8'h60);
      for (int j = 0; j < kept; j++) begin
        check("R12 tx_valid", tx_valid, 1);
        check("R5 tx order", tx_data, tx_pat(first + j));
        tx_take();
      end
      check("R12 tx drained", tx_valid, 0);
    end

    // R11 enable change flushes both sides
    for (int i = 0; i < 5; i++) reg_write(3'd0, tx_pat(i));
    rx_send(8'h12); rx_send(8'h34);
    reg_write(3'd2, 8'h40);
    check("R11 toggle tx flush", tx_valid, 0);
    check("R11 toggle rx flush", rx_count, 0);
    reg_read(3'd5, d); check("R11 toggle status", d, 8'h60);

    // R6 single-byte receive
    rx_send(8'h11);
    reg_read(3'd5, d); check("R6 first byte ready", d, 8'h61);
    rx_send(8'h22);
    reg_read(3'd5, d); check("R6 overrun", d, 8'h63);
    reg_read(3'd0, d); check("R6 replaced byte", d, 8'h22);
    reg_read(3'd5, d); check("R7 single read clears", d, 8'h60);
    rx_brk();
    reg_read(3'd0, d); check("R8 single break byte", d, 0);

    // R12 single-byte transmit
    reg_write(3'd0, 8'h33);
    check("R12 single valid", tx_valid, 1);
    check("R12 single data", tx_data, 8'h33);
    reg_write(3'd0, 8'h44);
    check("R12 single replace", tx_data, 8'h44);
    reg_read(3'd5, d); check("R12 single busy", d, 8'h00);
    tx_take();
    check("R12 single taken", tx_valid, 0);
    reg_read(3'd5, d); check("R12 single idle", d, 8'h60);

    finish_run();
  end

endmodule